// File: doc/BRIEF.md
# Serial LED Shift Driver

This block carries eight LED indications off chip over three wires to an external 595-style shift register that has a separate storage latch. It divides the system clock to make a slow LED clock, shifts one frame of eight bits into the external register on that clock, and then raises a latch strobe so that the external storage register shows the new byte on the LEDs. Frames repeat without pause, so the LEDs follow the inputs with a delay of about one frame.

Brief LED events would be too short to see, so each input may be stretched. When stretching is enabled, an input that goes active keeps its LED lit for a selectable hold time after the event ends. A two-bit select picks one of four hold times, counted in ticks of a slow time base whose period is a parameter and can be shortened for simulation. One invert input flips the polarity of every shifted bit, to suit LEDs wired active-low.

The stretched LED states are copied into a snapshot register at the start of every frame. The byte being shifted therefore cannot change partway through a frame. Serial data and latch change only while the LED clock is low: they change on its falling edge, or during the latch period when the clock is held low.

Top module: `led_serializer`

## Requirements
- R1: While rst_n is low, led_sclk, led_sdata and led_latch are all 0.
- R2: In each of the eight data slots of a frame, led_sclk is high for CLK_DIV system clock cycles and then low for CLK_DIV cycles. During the latch slot, led_sclk stays low.
- R3: led_sdata and led_latch never change while led_sclk is high. They change only on the cycle in which led_sclk falls or while it is low.
- R4: Between two consecutive rising edges of led_latch there are exactly LED_N (8) rising edges of led_sclk. led_latch stays high for 2*CLK_DIV cycles.
- R5: The bit for led_evt[7] is shifted first and the bit for led_evt[0] last. A 1 on led_sdata means the LED is on when invert is 0.
- R6: The LED states are captured once per frame, at the falling clock edge that starts data slot 0. An input change after that point does not alter the byte latched at the end of that frame. It appears in the next frame.
- R7: With stretch_en at 0, each shifted bit equals the current level of its input. A one-cycle pulse that falls between two snapshots does not appear in any frame.
- R8: With stretch_en at 1, an LED stays on after its input falls for at least (L-1)*TICK_CYC and at most L*TICK_CYC+1 cycles. L is 3, 6, 10 or 20 ticks for stretch_sel values 0, 1, 2 and 3. A new event while the LED is stretched reloads the full hold time.
- R9: With invert at 1, every shifted bit is the complement of the LED state.
- R10: Frames repeat continuously. Consecutive rising edges of led_latch are exactly (LED_N+1)*2*CLK_DIV cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| led_evt | input | LED_N | Raw LED event inputs, active high |
| stretch_en | input | 1 | 1 enables stretching of LED events |
| stretch_sel | input | 2 | Hold-time select: 0=3, 1=6, 2=10, 3=20 ticks |
| invert | input | 1 | 1 inverts every shifted bit |
| led_sclk | output | 1 | LED shift clock to the external register |
| led_sdata | output | 1 | Serial LED data, valid at rising led_sclk |
| led_latch | output | 1 | Latch strobe to the external storage register |

## Verification
A wrong slot or divider count shows at the ports within one frame: the latch rises after the wrong number of shift clocks, or the latch period or clock width is off. A corrupt snapshot or a wrong shift order shows as a wrong byte at the next latch, one frame after the inputs settle. Stretch counter errors show only after the hold time has run out. For that reason the bench reads back frames both before and after each expected end of a hold, so that a wrong length table or a counter that never stops is reported within about two frames of that point.

// File: rtl/led_ser_pkg.sv
package led_ser_pkg;

    localparam int unsigned HOLD_W = 5;

    // Hold time in ticks for each stretch select value
    function automatic logic [HOLD_W-1:0] hold_ticks(input logic [1:0] sel);
        logic [HOLD_W-1:0] t;
        unique case (sel)
            2'd0:    t = HOLD_W'(3);
            2'd1:    t = HOLD_W'(6);
            2'd2:    t = HOLD_W'(10);
            default: t = HOLD_W'(20);
        endcase
        return t;
    endfunction

endpackage

// File: rtl/led_tick_gen.sv
module led_tick_gen #(
    parameter int unsigned TICK_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int unsigned TW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;

    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          tick;
    } tick_st_t;

    tick_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == TW'(TICK_CYC - 1)) begin
            st_d.cnt  = '0;
            st_d.tick = 1'b1;
        end else begin
            st_d.cnt  = st_q.cnt + 1'b1;
            st_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o = st_q.tick;
endmodule

// File: rtl/led_stretch_cell.sv
module led_stretch_cell
    import led_ser_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_i,
    input  logic              en_i,
    input  logic              tick_i,
    input  logic [HOLD_W-1:0] hold_i,
    output logic              on_o
);
    typedef struct packed {
        logic [HOLD_W-1:0] cnt;
    } cell_st_t;

    cell_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en_i)
            st_d.cnt = '0;
        else if (evt_i)
            st_d.cnt = hold_i;
        else if (tick_i && st_q.cnt != '0)
            st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign on_o = evt_i | (en_i && st_q.cnt != '0);
endmodule

// File: rtl/led_frame_shifter.sv
module led_frame_shifter #(
    parameter int unsigned LED_N   = 8,
    parameter int unsigned CLK_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LED_N-1:0] state_i,
    input  logic             invert_i,
    output logic             sclk_o,
    output logic             sdata_o,
    output logic             latch_o
);
    localparam int unsigned DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam int unsigned SW    = $clog2(LED_N + 1);
    localparam logic [SW-1:0] LATCH_SLOT = SW'(LED_N);
    localparam logic [SW-1:0] LAST_DATA  = SW'(LED_N - 1);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             phase;
        logic [SW-1:0]    slot;
        logic [LED_N-1:0] snap;
        logic             sclk;
        logic             sdata;
        logic             latch;
    } shf_st_t;

    shf_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.div == DIV_W'(CLK_DIV - 1)) begin
            st_d.div   = '0;
            st_d.phase = ~st_q.phase;
            if (st_q.phase) begin
                // falling edge of the internal LED clock: advance one slot
                if (st_q.slot == LATCH_SLOT) begin
                    st_d.slot  = '0;
                    st_d.snap  = state_i ^ {LED_N{invert_i}};
                    st_d.sdata = st_d.snap[LED_N-1];
                    st_d.latch = 1'b0;
                end else if (st_q.slot == LAST_DATA) begin
                    st_d.slot  = LATCH_SLOT;
                    st_d.sdata = 1'b0;
                    st_d.latch = 1'b1;
                end else begin
                    st_d.slot  = st_q.slot + 1'b1;
                    st_d.snap  = {st_q.snap[LED_N-2:0], 1'b0};
                    st_d.sdata = st_d.snap[LED_N-1];
                end
            end
        end else begin
            st_d.div = st_q.div + 1'b1;
        end
        st_d.sclk = st_d.phase & (st_d.slot != LATCH_SLOT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.slot  <= LATCH_SLOT;
        end else begin
            st_q <= st_d;
        end
    end

    assign sclk_o  = st_q.sclk;
    assign sdata_o = st_q.sdata;
    assign latch_o = st_q.latch;
endmodule

// File: rtl/led_serializer.sv
module led_serializer
    import led_ser_pkg::*;
#(
    parameter int unsigned LED_N    = 8,
    parameter int unsigned CLK_DIV  = 4,
    parameter int unsigned TICK_CYC = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LED_N-1:0] led_evt,
    input  logic             stretch_en,
    input  logic [1:0]       stretch_sel,
    input  logic             invert,
    output logic             led_sclk,
    output logic             led_sdata,
    output logic             led_latch
);
    logic              tick;
    logic [HOLD_W-1:0] hold;
    logic [LED_N-1:0]  led_on;

    assign hold = hold_ticks(stretch_sel);

    led_tick_gen #(.TICK_CYC(TICK_CYC)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    for (genvar i = 0; i < LED_N; i++) begin : g_cell
        led_stretch_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt_i  (led_evt[i]),
            .en_i   (stretch_en),
            .tick_i (tick),
            .hold_i (hold),
            .on_o   (led_on[i])
        );
    end

    led_frame_shifter #(.LED_N(LED_N), .CLK_DIV(CLK_DIV)) u_shf (
        .clk      (clk),
        .rst_n    (rst_n),
        .state_i  (led_on),
        .invert_i (invert),
        .sclk_o   (led_sclk),
        .sdata_o  (led_sdata),
        .latch_o  (led_latch)
    );
endmodule

// File: rtl/led_serializer_chk.sv
module led_serializer_chk #(
    parameter int unsigned LED_N   = 8,
    parameter int unsigned CLK_DIV = 4
) (
    input logic clk,
    input logic rst_n,
    input logic led_sclk,
    input logic led_sdata,
    input logic led_latch
);
    localparam int unsigned FRAME_CYC = (LED_N + 1) * 2 * CLK_DIV;

    logic        p_sclk, p_latch, seen;
    int unsigned hi_cnt, rise_cnt, gap_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_sclk <= 1'b0; p_latch <= 1'b0; seen <= 1'b0;
            hi_cnt <= 0; rise_cnt <= 0; gap_cnt <= 0;
        end else begin
            p_sclk  <= led_sclk;
            p_latch <= led_latch;
            hi_cnt  <= led_sclk ? hi_cnt + 1 : 0;
            if (led_latch && !p_latch) begin
                rise_cnt <= 0;
                gap_cnt  <= 1;
                seen     <= 1'b1;
            end else begin
                gap_cnt <= gap_cnt + 1;
                if (led_sclk && !p_sclk) rise_cnt <= rise_cnt + 1;
            end
        end
    end

    always_comb begin
        if (!rst_n) begin
            a_r1_idle_in_reset: assert (!led_sclk && !led_sdata && !led_latch);
        end
    end

    a_r2_clk_high_width: assert property (@(posedge clk) disable iff (!rst_n)
        (!led_sclk && p_sclk) |-> hi_cnt == CLK_DIV);

    a_r2_no_clk_in_latch: assert property (@(posedge clk) disable iff (!rst_n)
        led_latch |-> !led_sclk);

    a_r3_sdata_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (led_sclk && p_sclk) |-> $stable(led_sdata));

    a_r3_latch_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (led_sclk && p_sclk) |-> $stable(led_latch));

    a_r4_eight_rises: assert property (@(posedge clk) disable iff (!rst_n)
        (led_latch && !p_latch) |-> rise_cnt == LED_N);

    a_r10_frame_period: assert property (@(posedge clk) disable iff (!rst_n)
        (led_latch && !p_latch && seen) |-> gap_cnt == FRAME_CYC);
endmodule

bind led_serializer led_serializer_chk #(.LED_N(LED_N), .CLK_DIV(CLK_DIV)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .led_sclk  (led_sclk),
    .led_sdata (led_sdata),
    .led_latch (led_latch)
);

// File: tb/led_serializer_test.sv
module led_serializer_test;
    localparam int unsigned LED_N    = 8;
    localparam int unsigned CLK_DIV  = 4;
    localparam int unsigned TICK_CYC = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] led_evt = '0;
    logic stretch_en = 1'b0;
    logic [1:0] stretch_sel = '0;
    logic invert = 1'b0;
    logic led_sclk, led_sdata, led_latch;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    led_serializer #(.LED_N(LED_N), .CLK_DIV(CLK_DIV), .TICK_CYC(TICK_CYC)) uut (
        .clk(clk), .rst_n(rst_n), .led_evt(led_evt), .stretch_en(stretch_en),
        .stretch_sel(stretch_sel), .invert(invert),
        .led_sclk(led_sclk), .led_sdata(led_sdata), .led_latch(led_latch)
    );

    // Port monitor: rebuilds the external shift register and measures timing
    logic [7:0] sh = '0, last_byte = '0;
    logic p_sclk = 0, p_lat = 0, p_sd = 0;
    int cyc = 0, rises = 0, last_rises = 0, hi_run = 0, last_hi = 0;
    int lat_run = 0, last_lat = 0, last_period = 0, last_rise_cyc = 0;
    int frame_cnt = 0, r3_viol = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            p_sclk = 0; p_lat = 0; p_sd = 0; rises = 0; hi_run = 0;
            lat_run = 0; frame_cnt = 0; cyc = 0;
        end else begin
            if (led_sclk && p_sclk && (led_sdata != p_sd || led_latch != p_lat))
                r3_viol++;
            if (led_sclk && !p_sclk) begin
                sh = {sh[6:0], led_sdata};
                rises++;
            end
            if (led_sclk) hi_run++;
            else if (p_sclk) begin last_hi = hi_run; hi_run = 0; end
            if (led_latch) lat_run++;
            else if (p_lat) begin last_lat = lat_run; lat_run = 0; end
            if (led_latch && !p_lat) begin
                last_byte = sh;
                last_rises = rises;
                rises = 0;
                if (frame_cnt > 0) last_period = cyc - last_rise_cyc;
                last_rise_cyc = cyc;
                frame_cnt++;
            end
            p_sclk = led_sclk; p_lat = led_latch; p_sd = led_sdata;
            cyc++;
        end
    end

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic next_frame();
        int s = frame_cnt;
        while (frame_cnt == s) @(negedge clk);
    endtask

    // two frames: the second one was captured after the call began
    task automatic fresh_frame();
        next_frame();
        next_frame();
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        idle(5);
        chk("R1", "sclk in reset", int'(led_sclk), 0);
        chk("R1", "sdata in reset", int'(led_sdata), 0);
        chk("R1", "latch in reset", int'(led_latch), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_pattern(input logic [7:0] v);
        led_evt = v;
        fresh_frame();
        chk("R5", $sformatf("byte for %02h", v), int'(last_byte), int'(v));
    endtask

    task automatic t_timing();
        fresh_frame();
        chk("R4", "sclk rises per frame", last_rises, LED_N);
        chk("R4", "latch high cycles", last_lat, 2 * CLK_DIV);
        chk("R2", "sclk high cycles", last_hi, CLK_DIV);
        chk("R10", "latch period", last_period, (LED_N + 1) * 2 * CLK_DIV);
        chk("R3", "data/latch moves while sclk high", r3_viol, 0);
    endtask

    task automatic t_r2_latch_slot();
        int hi_seen = 0;
        next_frame();
        while (led_latch) begin
            if (led_sclk) hi_seen++;
            @(negedge clk);
        end
        chk("R2", "sclk high during latch slot", hi_seen, 0);
    endtask

    task automatic t_snapshot();
        led_evt = 8'h0F;
        fresh_frame();
        while (!led_latch) @(negedge clk);
        while (led_latch) @(negedge clk);
        idle(10);
        led_evt = 8'hF0;
        next_frame();
        chk("R6", "frame keeps old snapshot", int'(last_byte), 8'h0F);
        next_frame();
        chk("R6", "next frame shows new value", int'(last_byte), 8'hF0);
    endtask

    task automatic t_invert();
        led_evt = 8'h5A;
        invert = 1'b1;
        fresh_frame();
        chk("R9", "inverted byte", int'(last_byte), 8'hA5);
        invert = 1'b0;
        fresh_frame();
        chk("R9", "invert released", int'(last_byte), 8'h5A);
    endtask

    task automatic pulse(input logic [7:0] v);
        led_evt = v;
        @(negedge clk);
        led_evt = '0;
    endtask

    task automatic t_no_stretch();
        stretch_en = 1'b0;
        led_evt = '0;
        fresh_frame();
        pulse(8'h10);
        fresh_frame();
        chk("R7", "short pulse not stretched", int'(last_byte), 0);
    endtask

    task automatic t_stretch(input logic [1:0] sel, input logic [7:0] v,
                             input int delay, input logic [7:0] exp, input string what);
        stretch_en = 1'b1;
        stretch_sel = sel;
        pulse(v);
        idle(delay);
        fresh_frame();
        chk("R8", what, int'(last_byte), int'(exp));
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_pattern(8'hA5);
                t_pattern(8'h3C);
                t_pattern(8'h81);
                t_pattern(8'hFF);
                t_pattern(8'h00);
                t_timing();
                t_r2_latch_slot();
                t_snapshot();
                t_invert();
                t_no_stretch();
                led_evt = '0;
                t_stretch(2'd3, 8'h04, 100, 8'h04, "sel3 still lit at +100");
                t_stretch(2'd3, 8'h04, 400, 8'h00, "sel3 dark at +400");
                t_stretch(2'd2, 8'h40, 50, 8'h40, "sel2 still lit at +50");
                idle(200);
                fresh_frame();
                chk("R8", "sel2 dark after hold", int'(last_byte), 0);
                t_stretch(2'd0, 8'h02, 70, 8'h00, "sel0 dark at +70");
                t_timing();
            end
            begin
                repeat (100000) @(posedge clk);
                fails++;
                checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule